// File: doc/BRIEF.md
# Two-Task Page Translation Unit

This block widens a 16-bit CPU address to a larger physical address. It splits the CPU space into eight 8KB pages. CPU address bits 15..13 pick one of eight page registers, and that register's contents become the upper physical address bits. Bits 12..0 pass through unchanged. With the default 8-bit page registers the physical space is 2MB; a 6-bit build reaches 512KB.

The unit holds two register sets, one for a user task and one for a system task, so an interrupt handler can run in its own map. A one-cycle pulse on the entry input selects the system set. Software goes back to the user set by writing to a task-control register. All registers sit in a small window in the I/O area. While the window is addressed, the memory enable is dropped so the access never reaches mapped memory. At reset the system set is active, and both sets map pages 0 to 7 in order.

Top module: `pgmap_unit`

## Requirements
- R1: After reset `task_sys` is 1, and every page register in both sets holds its own index (register n holds n), so the map is the identity.
- R2: `phys_addr` equals the selected page register concatenated above `cpu_addr[12:0]`. The register index is `cpu_addr[15:13]`, and the low 13 bits pass through unchanged.
- R3: When `task_sys` is 1 the system set translates; when it is 0 the user set translates.
- R4: A write (`win_sel`=1, `cpu_we`=1) at window offset `cpu_addr[4:0]` 0..7 loads user register 0..7, and at offset 8..15 loads system register 0..7. The register takes the low PAGE_W bits of `cpu_wdata`, and the new value is in effect from the next clock cycle.
- R5: When `win_sel` is 1, `rd_data` returns the addressed page register zero-extended at offsets 0..15. It returns `{7'b0, task_sys}` at offset 16 and 0 at offsets 17..31. When `win_sel` is 0, `rd_data` is 0.
- R6: A cycle with `sys_enter`=1 makes `task_sys` 1 from the next cycle.
- R7: A write at offset 16 makes `task_sys` 0 from the next cycle, whatever the data. If `sys_enter` is 1 in the same cycle, the system task wins. Without either event, `task_sys` holds its value.
- R8: `mem_en` is the inverse of `win_sel`, so window accesses never go to mapped memory.
- R9: Window reads (`cpu_we`=0) and writes with `win_sel`=0 leave every page register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe |
| win_sel | input | 1 | Register window decode from the I/O area |
| sys_enter | input | 1 | Pulse that forces the system task |
| rd_data | output | 8 | Register window read data |
| phys_addr | output | PAGE_W+13 | Translated physical address |
| mem_en | output | 1 | Memory access enable, low during window accesses |
| task_sys | output | 1 | 1 when the system set is active |

## Verification
The hardest case to reach is the interaction between the two sets and the task bit. A page written into one set must show up only while that set is active. The contents of the other set must survive a switch away and back. The stimulus therefore mixes random writes to both halves of the window with frequent control-register writes and entry pulses. A bench model of both sets predicts every translated address and every readback. Directed steps cover the case where the entry pulse and the control write arrive together, and accesses that must leave the registers unchanged.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  localparam int OFS_W   = 13;
  localparam int IDX_W   = 3;
  localparam int NREG    = 1 << IDX_W;
  localparam int WIN_AW  = 5;
  localparam logic [WIN_AW-1:0] CTRL_OFS = 5'h10;

  typedef struct packed {
    logic             is_page;
    logic             is_ctrl;
    logic             set_sel;
    logic [IDX_W-1:0] idx;
  } win_dec_t;

  function automatic win_dec_t win_decode(logic [WIN_AW-1:0] ofs);
    win_dec_t d;
    d.is_page = ~ofs[WIN_AW-1];
    d.is_ctrl = (ofs == CTRL_OFS);
    d.set_sel = ofs[IDX_W];
    d.idx     = ofs[IDX_W-1:0];
    return d;
  endfunction

  function automatic logic [IDX_W-1:0] page_index(logic [15:0] a);
    return a[15:OFS_W];
  endfunction
endpackage

// File: rtl/pgmap_bank.sv
module pgmap_bank #(
  parameter int PAGE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [pgmap_pkg::IDX_W-1:0] wr_idx,
  input  logic [PAGE_W-1:0]           wr_val,
  input  logic [pgmap_pkg::IDX_W-1:0] xl_idx,
  output logic [PAGE_W-1:0]           xl_page,
  output logic [PAGE_W-1:0]           rd_page
);
  import pgmap_pkg::*;
  logic [PAGE_W-1:0] pg [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        pg[i] <= PAGE_W'(i);
      else if (wr_en && (wr_idx == IDX_W'(i)))
        pg[i] <= wr_val;
    end
  end

  assign xl_page = pg[xl_idx];
  assign rd_page = pg[wr_idx];
endmodule

// File: rtl/pgmap_taskctl.sv
module pgmap_taskctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic leave,
  output logic sys
);
  always_ff @(posedge clk) begin
    if (!rst_n)     sys <= 1'b1;
    else if (enter) sys <= 1'b1;
    else if (leave) sys <= 1'b0;
  end
endmodule

// File: rtl/pgmap_unit.sv
module pgmap_unit #(
  parameter int PAGE_W    = 8,
  parameter int DUAL_TASK = 1,
  parameter int DATA_W    = 8,
  parameter int PA_W      = PAGE_W + pgmap_pkg::OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic              win_sel,
  input  logic              sys_enter,
  output logic [DATA_W-1:0] rd_data,
  output logic [PA_W-1:0]   phys_addr,
  output logic              mem_en,
  output logic              task_sys
);
  import pgmap_pkg::*;
  localparam int NSETS = (DUAL_TASK != 0) ? 2 : 1;

  win_dec_t          dec;
  logic              wr_fire;
  logic              ctrl_wr;
  logic              page_wr;
  logic [IDX_W-1:0]  xl_idx;
  logic [PAGE_W-1:0] xl_pg [NSETS];
  logic [PAGE_W-1:0] rb_pg [NSETS];
  logic [PAGE_W-1:0] act_page;
  logic [PAGE_W-1:0] rd_page;

  assign dec     = win_decode(cpu_addr[WIN_AW-1:0]);
  assign wr_fire = win_sel && cpu_we;
  assign ctrl_wr = wr_fire && dec.is_ctrl;
  assign page_wr = wr_fire && dec.is_page;
  assign xl_idx  = page_index(cpu_addr);

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    logic hit;
    if (NSETS == 1) begin : g_one
      assign hit = 1'b1;
    end else begin : g_two
      assign hit = (dec.set_sel == s[0]);
    end
    pgmap_bank #(.PAGE_W(PAGE_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (page_wr && hit),
      .wr_idx (dec.idx),
      .wr_val (cpu_wdata[PAGE_W-1:0]),
      .xl_idx (xl_idx),
      .xl_page(xl_pg[s]),
      .rd_page(rb_pg[s])
    );
  end

  pgmap_taskctl u_task (
    .clk  (clk),
    .rst_n(rst_n),
    .enter(sys_enter),
    .leave(ctrl_wr),
    .sys  (task_sys)
  );

  if (NSETS == 2) begin : g_sel2
    assign act_page = task_sys    ? xl_pg[1] : xl_pg[0];
    assign rd_page  = dec.set_sel ? rb_pg[1] : rb_pg[0];
  end else begin : g_sel1
    assign act_page = xl_pg[0];
    assign rd_page  = rb_pg[0];
  end

  assign phys_addr = {act_page, cpu_addr[OFS_W-1:0]};
  assign mem_en    = ~win_sel;

  always_comb begin
    rd_data = '0;
    if (win_sel) begin
      if (dec.is_page)      rd_data[PAGE_W-1:0] = rd_page;
      else if (dec.is_ctrl) rd_data[0] = task_sys;
    end
  end
endmodule

// File: rtl/pgmap_chk.sv
module pgmap_chk #(
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [15:0]              cpu_addr,
  input logic                     win_sel,
  input logic                     sys_enter,
  input logic                     ctrl_wr,
  input logic [DATA_W-1:0]        rd_data,
  input logic [PAGE_W+12:0]       phys_addr,
  input logic                     mem_en,
  input logic                     task_sys
);
  // R6
  enter_sets_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_enter |=> task_sys);
  // R7
  ctrl_clears_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !sys_enter) |=> !task_sys);
  // R7
  task_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !sys_enter) |=> $stable(task_sys));
  // R8
  win_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_sel |-> !mem_en);
  // R8
  mem_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_sel |-> mem_en);
  // R2
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[12:0] == cpu_addr[12:0]);
  // R5
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_sel |-> (rd_data == '0));
endmodule

bind pgmap_unit pgmap_chk #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_addr (cpu_addr),
  .win_sel  (win_sel),
  .sys_enter(sys_enter),
  .ctrl_wr  (ctrl_wr),
  .rd_data  (rd_data),
  .phys_addr(phys_addr),
  .mem_en   (mem_en),
  .task_sys (task_sys)
);

// File: tb/sim_pgmap_unit.sv
module sim_pgmap_unit;
  localparam int PW = 8;
  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0, rd_data;
  logic cpu_we = 0, win_sel = 0, sys_enter = 0, mem_en, task_sys;
  logic [PW+12:0] phys_addr;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [PW-1:0] m_usr [8], m_sys [8];
  logic m_task;

  always #10 clk = ~clk;

  pgmap_unit u0 (.clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .win_sel(win_sel), .sys_enter(sys_enter), .rd_data(rd_data),
    .phys_addr(phys_addr), .mem_en(mem_en), .task_sys(task_sys));

  function automatic logic [PW+12:0] exp_phys(logic [15:0] a);
    logic [PW-1:0] p = m_task ? m_sys[a[15:13]] : m_usr[a[15:13]];
    return {p, a[12:0]};
  endfunction

  function automatic logic [7:0] exp_rd(logic ws, logic [15:0] a);
    int o = int'(a[4:0]);
    if (!ws) return 8'h0;
    if (o < 8)   return 8'(m_usr[o]);
    if (o < 16)  return 8'(m_sys[o-8]);
    if (o == 16) return {7'b0, m_task};
    return 8'h0;
  endfunction

  task automatic chk(string tg, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tg, act, exp);
    end
  endtask

  task automatic step(logic ws, logic we, logic [15:0] a, logic [7:0] wd, logic tr, string tg);
    int o;
    @(negedge clk);
    win_sel = ws; cpu_we = we; cpu_addr = a; cpu_wdata = wd; sys_enter = tr;
    #2;
    chk({tg, " phys"}, 32'(phys_addr), 32'(exp_phys(a)));
    chk("R8 mem_en", 32'(mem_en), 32'(!ws));
    chk("R5 rd_data", 32'(rd_data), 32'(exp_rd(ws, a)));
    chk("R7 task_sys", 32'(task_sys), 32'(m_task));
    @(posedge clk); #1;
    o = int'(a[4:0]);
    if (ws && we) begin
      if (o < 8) m_usr[o] = wd[PW-1:0];
      else if (o < 16) m_sys[o-8] = wd[PW-1:0];
    end
    if (tr) m_task = 1'b1;
    else if (ws && we && o == 16) m_task = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin m_usr[i] = PW'(i); m_sys[i] = PW'(i); end
    m_task = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #2;
    chk("R1 reset task", 32'(task_sys), 32'd1);
    // R1: identity map in the system set, and readback of both sets
    for (int i = 0; i < 8; i++) step(0, 0, {3'(i), 13'h0abc}, 0, 0, "R1");
    for (int i = 0; i < 16; i++) step(1, 0, 16'(i), 8'hff, 0, "R1");
    // R4: write system reg 2, used from the next cycle
    step(1, 1, 16'h000a, 8'h5c, 0, "R4");
    step(0, 0, 16'h4123, 0, 0, "R4");
    // R7: clear to user, then R3: the user set translates
    step(1, 1, 16'h0010, 8'h00, 0, "R7");
    step(1, 1, 16'h0002, 8'h91, 0, "R4");
    step(0, 0, 16'h5fff, 0, 0, "R3");
    // R7: entry and control write together, system wins
    step(1, 1, 16'h0010, 8'h00, 1, "R7");
    step(0, 0, 16'h5fff, 0, 0, "R3");
    // R9: window read with data, and write outside the window
    step(1, 0, 16'h0003, 8'h77, 0, "R9");
    step(0, 1, 16'h0003, 8'h77, 0, "R9");
    step(1, 0, 16'h0003, 8'h00, 0, "R9");
    step(1, 0, 16'h0013, 8'h00, 0, "R5");
    // R6: entry pulse from the user task
    step(1, 1, 16'hff10, 8'h3c, 0, "R7");
    step(0, 0, 16'hc000, 0, 1, "R6");
    step(0, 0, 16'hc000, 0, 0, "R6");
    // random traffic over both sets and the task bit
    for (int n = 0; n < 3000; n++) begin
      logic ws = ($urandom % 2) == 0;
      logic [15:0] a = 16'($urandom);
      if (ws) a[4:0] = 5'($urandom % 18);
      step(ws, 1'($urandom), a, 8'($urandom), ($urandom % 10) == 0, ws ? "R4" : "R2");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule